// File: doc/BRIEF.md
# Trace Message Injector with Hardware Event Capture

This block merges two producers of trace messages into one outgoing message stream with a valid/ready handshake. Software deposits a message through a simple memory-mapped write port. The write address picks one of three segments and, inside that segment, one of 65536 stimulus channels. Each channel owns a 256-byte address window. The written data becomes the message payload.

The second producer is a 32-bit vector of hardware event lines. Every rising edge on a line becomes one message that carries the line's index. Lines 0 to 3 belong to the cross-trigger group and lines 4 to 31 to the user-logic group. A flag in the message tells the two groups apart.

A detected edge is kept as a pending request until the message is issued, so a one-cycle pulse is not lost while the consumer stalls. Each message can carry a timestamp taken from a free-running counter. A configuration input decides whether the timestamp field is marked valid.

Top module: `trace_injector`

## Requirements
- R1: A software write to address A produces one message with source 0, segment A[25:24], id A[23:8] and payload equal to the written data. Address bits A[7:0] have no effect on the message.
- R2: A write whose segment field A[25:24] equals 3 is accepted with wr_ready high. It produces no message, and seg_err is high in the cycle after the accepting clock edge.
- R3: wr_ready is low from the clock edge that accepts a valid-segment write until that software message moves into the output register.
- R4: A rising edge on event line i produces one message with source 1, id i, segment 0 and payload 0. A falling edge produces nothing.
- R5: For a hardware message, grp is 1 when the id is 0 to 3 and 0 when the id is 4 to 31. Software messages carry grp 0.
- R6: A pulse on an event line that lasts a single clock is held as pending while the output stalls, and is issued later.
- R7: The output register is refilled only when it is empty or its message is accepted. Pending hardware events win over a waiting software message, and the lowest pending index goes first. Each message appears exactly once.
- R8: A rising edge on a line whose earlier edge is still pending adds one to ovf_count. ovf_count saturates at 255.
- R9: A message is created when it is loaded into the output register. m_ts_valid equals ts_enable in that cycle. m_ts equals the counter value in that cycle. The counter is 0 at the first clock edge after reset, adds one every clock and wraps.
- R10: After reset, m_valid and ovf_count are 0 and wr_ready is 1. Event lines that are already high when reset is released produce no message.
- R11: While m_valid is high and m_ready is low, every message output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Software write request |
| wr_ready | output | 1 | Write port can accept a request |
| wr_addr | input | 26 | Write address: segment [25:24], channel [23:8], offset [7:0] |
| wr_data | input | 32 | Write data, used as the message payload |
| evt_in | input | 32 | Hardware event lines |
| ts_enable | input | 1 | Marks the timestamp of newly created messages as valid |
| m_valid | output | 1 | Output message valid |
| m_ready | input | 1 | Consumer accepts the output message |
| m_src | output | 1 | Message source: 0 software, 1 hardware |
| m_grp | output | 1 | Hardware group: 1 cross-trigger lines 0..3, 0 otherwise |
| m_seg | output | 2 | Segment of a software message |
| m_id | output | 16 | Channel number or event index |
| m_payload | output | 32 | Software data, 0 for hardware messages |
| m_ts_valid | output | 1 | Timestamp field is meaningful |
| m_ts | output | 32 | Counter value when the message was created |
| seg_err | output | 1 | One-cycle strobe for a write to the invalid segment |
| ovf_count | output | 8 | Saturating count of edges lost on still-pending lines |

## Verification
The hardest state to reach is several requests waiting at the same moment: a message parked in the output register, several event lines pending, and a software message in the buffer. The stimulus builds this by holding m_ready low. It then parks a software message in the output register, fires single-cycle pulses on lines out of index order, and buffers a second write before releasing the consumer. The scoreboard then expects the lowest index first and the software message last. The overflow counter is pushed into saturation with repeated pulses on a single line while its first edge stays pending behind the stalled output.

// File: rtl/tinj_pkg.sv
package tinj_pkg;
  typedef enum logic {
    SRC_SW = 1'b0,
    SRC_HW = 1'b1
  } src_e;
endpackage

// File: rtl/tinj_evt_capture.sv
// Samples the event lines, detects rising edges, keeps a sticky pending bit
// per line and counts edges that hit a line that is still pending.
module tinj_evt_capture #(
  parameter int NUM_EVT = 32,
  parameter int OVF_W   = 8,
  parameter int IDX_W   = $clog2(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               take,
  output logic               pend_any,
  output logic [IDX_W-1:0]   pend_idx,
  output logic [OVF_W-1:0]   ovf_count
);
  localparam int SUM_W = OVF_W + IDX_W + 1;
  localparam logic [SUM_W-1:0] OVF_MAX = SUM_W'({OVF_W{1'b1}});

  logic [NUM_EVT-1:0] smp_q, hist_q, pend_q;
  logic               arm0_q, arm1_q;
  logic [NUM_EVT-1:0] rise, clr_mask, dup;
  logic [OVF_W-1:0]   ovf_q;
  logic [SUM_W-1:0]   dup_cnt, ovf_sum;

  // arm1_q marks the cycle from which both samples are real input values.
  // Lines that are high when reset is released therefore show no edge.
  assign rise = smp_q & ~hist_q & {NUM_EVT{arm1_q}};

  always_comb begin
    pend_idx = '0;
    pend_any = 1'b0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        pend_idx = IDX_W'(i);
        pend_any = 1'b1;
      end
    end
  end

  assign clr_mask = take ? (NUM_EVT'(1) << pend_idx) : '0;
  assign dup      = rise & pend_q & ~clr_mask;

  always_comb begin
    dup_cnt = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      dup_cnt = dup_cnt + SUM_W'(dup[i]);
    end
    ovf_sum = SUM_W'(ovf_q) + dup_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q  <= '0;
      hist_q <= '0;
      pend_q <= '0;
      arm0_q <= 1'b0;
      arm1_q <= 1'b0;
      ovf_q  <= '0;
    end else begin
      smp_q  <= evt_in;
      hist_q <= smp_q;
      arm0_q <= 1'b1;
      arm1_q <= arm0_q;
      pend_q <= (pend_q & ~clr_mask) | rise;
      ovf_q  <= (ovf_sum > OVF_MAX) ? OVF_MAX[OVF_W-1:0] : ovf_sum[OVF_W-1:0];
    end
  end

  assign ovf_count = ovf_q;
endmodule

// File: rtl/tinj_sw_port.sv
// Decodes the write address into segment and channel and holds one
// software message until the output stage takes it.
module tinj_sw_port #(
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 32,
  parameter int CH_W    = 16,
  parameter int SEG_W   = 2,
  parameter int WIN_W   = 8,
  parameter int NUM_SEG = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              buf_valid,
  output logic [SEG_W-1:0]  buf_seg,
  output logic [CH_W-1:0]   buf_ch,
  output logic [DATA_W-1:0] buf_data,
  output logic              seg_err
);
  localparam int SEG_LSB = WIN_W + CH_W;

  logic [SEG_W-1:0] dec_seg;
  logic [CH_W-1:0]  dec_ch;
  logic             acc, seg_bad;
  logic             full_q, err_q;
  logic [SEG_W-1:0] seg_q;
  logic [CH_W-1:0]  ch_q;
  logic [DATA_W-1:0] data_q;

  assign dec_seg = wr_addr[SEG_LSB +: SEG_W];
  assign dec_ch  = wr_addr[WIN_W +: CH_W];
  assign seg_bad = (32'(dec_seg) >= NUM_SEG);
  assign acc     = wr_valid && !full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      err_q  <= 1'b0;
      seg_q  <= '0;
      ch_q   <= '0;
      data_q <= '0;
    end else begin
      err_q <= acc && seg_bad;
      if (acc && !seg_bad) begin
        full_q <= 1'b1;
        seg_q  <= dec_seg;
        ch_q   <= dec_ch;
        data_q <= wr_data;
      end else if (take) begin
        full_q <= 1'b0;
      end
    end
  end

  assign wr_ready  = !full_q;
  assign buf_valid = full_q;
  assign buf_seg   = seg_q;
  assign buf_ch    = ch_q;
  assign buf_data  = data_q;
  assign seg_err   = err_q;
endmodule

// File: rtl/tinj_out_stage.sv
// Chooses the next message, loads the output register and stamps the time.
module tinj_out_stage #(
  parameter int DATA_W  = 32,
  parameter int CH_W    = 16,
  parameter int SEG_W   = 2,
  parameter int TS_W    = 32,
  parameter int IDX_W   = 5,
  parameter int CTI_EVT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pend_any,
  input  logic [IDX_W-1:0]  pend_idx,
  input  logic              buf_valid,
  input  logic [SEG_W-1:0]  buf_seg,
  input  logic [CH_W-1:0]   buf_ch,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              ts_enable,
  input  logic              m_ready,
  output logic              take_hw,
  output logic              take_sw,
  output logic              m_valid,
  output logic              m_src,
  output logic              m_grp,
  output logic [SEG_W-1:0]  m_seg,
  output logic [CH_W-1:0]   m_id,
  output logic [DATA_W-1:0] m_payload,
  output logic              m_ts_valid,
  output logic [TS_W-1:0]   m_ts
);
  import tinj_pkg::*;

  logic             load_en;
  logic [TS_W-1:0]  ts_q;
  logic             vld_q, grp_q, tsv_q;
  src_e             src_q;
  logic [SEG_W-1:0] seg_q;
  logic [CH_W-1:0]  id_q;
  logic [DATA_W-1:0] pay_q;
  logic [TS_W-1:0]  tss_q;

  assign load_en = !vld_q || m_ready;
  assign take_hw = load_en && pend_any;
  assign take_sw = load_en && !pend_any && buf_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_q  <= '0;
      vld_q <= 1'b0;
      src_q <= SRC_SW;
      grp_q <= 1'b0;
      seg_q <= '0;
      id_q  <= '0;
      pay_q <= '0;
      tsv_q <= 1'b0;
      tss_q <= '0;
    end else begin
      ts_q <= ts_q + 1'b1;
      if (load_en) begin
        vld_q <= pend_any || buf_valid;
        tsv_q <= ts_enable;
        tss_q <= ts_q;
        if (pend_any) begin
          src_q <= SRC_HW;
          grp_q <= (32'(pend_idx) < CTI_EVT);
          seg_q <= '0;
          id_q  <= CH_W'(pend_idx);
          pay_q <= '0;
        end else if (buf_valid) begin
          src_q <= SRC_SW;
          grp_q <= 1'b0;
          seg_q <= buf_seg;
          id_q  <= buf_ch;
          pay_q <= buf_data;
        end
      end
    end
  end

  assign m_valid    = vld_q;
  assign m_src      = src_q;
  assign m_grp      = grp_q;
  assign m_seg      = seg_q;
  assign m_id       = id_q;
  assign m_payload  = pay_q;
  assign m_ts_valid = tsv_q;
  assign m_ts       = tss_q;
endmodule

// File: rtl/trace_injector.sv
module trace_injector #(
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 32,
  parameter int CH_W    = 16,
  parameter int SEG_W   = 2,
  parameter int WIN_W   = 8,
  parameter int NUM_SEG = 3,
  parameter int NUM_EVT = 32,
  parameter int CTI_EVT = 4,
  parameter int TS_W    = 32,
  parameter int OVF_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               ts_enable,
  output logic               m_valid,
  input  logic               m_ready,
  output logic               m_src,
  output logic               m_grp,
  output logic [SEG_W-1:0]   m_seg,
  output logic [CH_W-1:0]    m_id,
  output logic [DATA_W-1:0]  m_payload,
  output logic               m_ts_valid,
  output logic [TS_W-1:0]    m_ts,
  output logic               seg_err,
  output logic [OVF_W-1:0]   ovf_count
);
  localparam int IDX_W = $clog2(NUM_EVT);

  logic             take_hw, take_sw, pend_any, buf_valid;
  logic [IDX_W-1:0] pend_idx;
  logic [SEG_W-1:0] buf_seg;
  logic [CH_W-1:0]  buf_ch;
  logic [DATA_W-1:0] buf_data;

  tinj_evt_capture #(
    .NUM_EVT(NUM_EVT), .OVF_W(OVF_W), .IDX_W(IDX_W)
  ) u_evt (
    .clk(clk), .rst(rst), .evt_in(evt_in), .take(take_hw),
    .pend_any(pend_any), .pend_idx(pend_idx), .ovf_count(ovf_count)
  );

  tinj_sw_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W), .SEG_W(SEG_W),
    .WIN_W(WIN_W), .NUM_SEG(NUM_SEG)
  ) u_sw (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .take(take_sw),
    .buf_valid(buf_valid), .buf_seg(buf_seg), .buf_ch(buf_ch),
    .buf_data(buf_data), .seg_err(seg_err)
  );

  tinj_out_stage #(
    .DATA_W(DATA_W), .CH_W(CH_W), .SEG_W(SEG_W), .TS_W(TS_W),
    .IDX_W(IDX_W), .CTI_EVT(CTI_EVT)
  ) u_out (
    .clk(clk), .rst(rst), .pend_any(pend_any), .pend_idx(pend_idx),
    .buf_valid(buf_valid), .buf_seg(buf_seg), .buf_ch(buf_ch),
    .buf_data(buf_data), .ts_enable(ts_enable), .m_ready(m_ready),
    .take_hw(take_hw), .take_sw(take_sw), .m_valid(m_valid),
    .m_src(m_src), .m_grp(m_grp), .m_seg(m_seg), .m_id(m_id),
    .m_payload(m_payload), .m_ts_valid(m_ts_valid), .m_ts(m_ts)
  );
endmodule

// File: rtl/trace_injector_chk.sv
module trace_injector_chk #(
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 32,
  parameter int CH_W    = 16,
  parameter int SEG_W   = 2,
  parameter int WIN_W   = 8,
  parameter int NUM_SEG = 3,
  parameter int NUM_EVT = 32,
  parameter int CTI_EVT = 4,
  parameter int TS_W    = 32,
  parameter int OVF_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic [NUM_EVT-1:0] evt_in,
  input logic               ts_enable,
  input logic               m_valid,
  input logic               m_ready,
  input logic               m_src,
  input logic               m_grp,
  input logic [SEG_W-1:0]   m_seg,
  input logic [CH_W-1:0]    m_id,
  input logic [DATA_W-1:0]  m_payload,
  input logic               m_ts_valid,
  input logic [TS_W-1:0]    m_ts,
  input logic               seg_err,
  input logic [OVF_W-1:0]   ovf_count
);
  localparam int SEG_LSB = WIN_W + CH_W;

  logic wr_ok_acc, wr_bad_acc;
  assign wr_ok_acc  = wr_valid && wr_ready && (32'(wr_addr[SEG_LSB +: SEG_W]) < NUM_SEG);
  assign wr_bad_acc = wr_valid && wr_ready && (32'(wr_addr[SEG_LSB +: SEG_W]) >= NUM_SEG);

  // R1: software messages never carry the invalid segment
  a_r1_seg_valid: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_src) |-> (32'(m_seg) < NUM_SEG));

  // R2: the error strobe follows an accepted invalid-segment write
  a_r2_err_cause: assert property (@(posedge clk) disable iff (rst)
    seg_err |-> $past(wr_bad_acc));

  // R2: an accepted invalid-segment write raises the strobe
  a_r2_err_raise: assert property (@(posedge clk) disable iff (rst)
    wr_bad_acc |=> seg_err);

  // R3: an accepted valid write closes the write port
  a_r3_ready_low: assert property (@(posedge clk) disable iff (rst)
    wr_ok_acc |=> !wr_ready);

  // R4: hardware messages carry no segment and no payload
  a_r4_hw_fields: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_src) |-> (m_payload == '0 && m_seg == '0 && 32'(m_id) < NUM_EVT));

  // R5: group flag matches the event index range
  a_r5_group: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> (m_grp == (m_src && (32'(m_id) < CTI_EVT))));

  // R8: the overflow count never decreases
  a_r8_ovf_mono: assert property (@(posedge clk) disable iff (rst)
    !$fell(rst) |-> (ovf_count >= $past(ovf_count)));

  // R10: no message right after reset
  a_r10_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!m_valid && ovf_count == '0));

  // R11: a stalled message holds its fields
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_src) && $stable(m_id)
      && $stable(m_seg) && $stable(m_payload) && $stable(m_ts) && $stable(m_ts_valid)));
endmodule

bind trace_injector trace_injector_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W), .SEG_W(SEG_W),
  .WIN_W(WIN_W), .NUM_SEG(NUM_SEG), .NUM_EVT(NUM_EVT), .CTI_EVT(CTI_EVT),
  .TS_W(TS_W), .OVF_W(OVF_W)
) u_chk (.*);

// File: tb/test_trace_injector.sv
`timescale 1ns/1ps
module test_trace_injector;
  typedef struct packed {
    logic        src;
    logic        grp;
    logic [1:0]  seg;
    logic [15:0] id;
    logic [31:0] payload;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [25:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] evt_in = '0;
  logic        ts_enable = 1'b1;
  logic        m_valid, m_ready = 1'b1;
  logic        m_src, m_grp, m_ts_valid, seg_err;
  logic [1:0]  m_seg;
  logic [15:0] m_id;
  logic [31:0] m_payload, m_ts;
  logic [7:0]  ovf_count;

  int   n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] tsm = '0;
  exp_t q[$];
  logic prev_valid = 1'b0, prev_hs = 1'b0, prev_tsen = 1'b0;

  trace_injector i_trace_injector (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .evt_in(evt_in),
    .ts_enable(ts_enable), .m_valid(m_valid), .m_ready(m_ready),
    .m_src(m_src), .m_grp(m_grp), .m_seg(m_seg), .m_id(m_id),
    .m_payload(m_payload), .m_ts_valid(m_ts_valid), .m_ts(m_ts),
    .seg_err(seg_err), .ovf_count(ovf_count)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // timestamp model: zero at the first edge after reset, +1 per clock
  always @(posedge clk) begin
    tsm <= rst ? 32'd0 : tsm + 32'd1;
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      check(1'b0, "watchdog (all requirements)", 64'(cyc), 64'd150000);
      finish_run();
    end
  end

  // monitor and scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (m_valid && (!prev_valid || prev_hs)) begin
        check(m_ts_valid == prev_tsen, "R9 ts_valid", 64'(m_ts_valid), 64'(prev_tsen));
        if (m_ts_valid) check(m_ts == tsm - 32'd1, "R9 timestamp", 64'(m_ts), 64'(tsm - 32'd1));
      end
      if (m_valid && m_ready) begin
        exp_t got;
        got = '{m_src, m_grp, m_seg, m_id, m_payload};
        if (q.size() == 0) begin
          check(1'b0, "R7 unexpected message", 64'(got), 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(got == e, "R1/R4/R5/R7 message", 64'(got), 64'(e));
        end
      end
      prev_valid <= m_valid;
      prev_hs    <= m_valid && m_ready;
      prev_tsen  <= ts_enable;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic sw_write(input logic [1:0] seg, input logic [15:0] ch,
                          input logic [7:0] off, input logic [31:0] data, input bit push);
    @(posedge clk); #2;
    wr_valid = 1'b1; wr_addr = {seg, ch, off}; wr_data = data;
    forever begin
      @(negedge clk);
      if (wr_ready) break;
    end
    @(posedge clk); #2;
    wr_valid = 1'b0;
    if (push) q.push_back('{1'b0, 1'b0, seg, ch, data});
  endtask

  task automatic pulse(input int idx, input bit push);
    @(posedge clk); #2; evt_in[idx] = 1'b1;
    @(posedge clk); #2; evt_in[idx] = 1'b0;
    if (push) q.push_back('{1'b1, (idx < 4), 2'd0, 16'(idx), 32'd0});
  endtask

  task automatic drain();
    m_ready = 1'b1;
    for (int i = 0; i < 200; i++) begin
      if (q.size() == 0 && !m_valid) break;
      wait_cyc(1);
    end
    wait_cyc(3);
  endtask

  initial begin
    // R10: lines high across reset release give no message
    evt_in[7] = 1'b1; evt_in[2] = 1'b1;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);
    check(m_valid == 1'b0 && ovf_count == 8'd0, "R10 reset outputs", {m_valid, ovf_count}, 64'd0);
    check(wr_ready == 1'b1, "R10 wr_ready after reset", 64'(wr_ready), 64'd1);
    wait_cyc(8);
    check(m_valid == 1'b0, "R10 no message from held-high lines", 64'(m_valid), 64'd0);
    evt_in = '0;   // R4: falling edges give nothing
    wait_cyc(6);
    check(m_valid == 1'b0, "R4 falling edge silent", 64'(m_valid), 64'd0);

    // R1: writes in each valid segment, offset bits varied
    sw_write(2'd0, 16'h1234, 8'h5c, 32'hdeadbeef, 1);
    sw_write(2'd1, 16'hffff, 8'hff, 32'h00000001, 1);
    sw_write(2'd2, 16'h0000, 8'h00, 32'ha5a55a5a, 1);
    drain();
    check(q.size() == 0, "R1 all software messages seen", 64'(q.size()), 64'd0);

    // R2: invalid segment
    sw_write(2'd3, 16'h0042, 8'h10, 32'h11111111, 0);
    check(seg_err == 1'b1, "R2 seg_err raised", 64'(seg_err), 64'd1);
    check(wr_ready == 1'b1, "R2 write port stays open", 64'(wr_ready), 64'd1);
    wait_cyc(1);
    check(seg_err == 1'b0, "R2 seg_err one cycle", 64'(seg_err), 64'd0);
    wait_cyc(4);
    check(m_valid == 1'b0, "R2 no message", 64'(m_valid), 64'd0);

    // R3: buffer full while output stalls
    m_ready = 1'b0;
    sw_write(2'd0, 16'h0001, 8'h00, 32'h0000aaaa, 1);
    sw_write(2'd1, 16'h0002, 8'h00, 32'h0000bbbb, 1);
    check(wr_ready == 1'b0, "R3 wr_ready low while waiting", 64'(wr_ready), 64'd0);
    wait_cyc(3);
    check(wr_ready == 1'b0, "R3 wr_ready stays low", 64'(wr_ready), 64'd0);
    drain();
    check(wr_ready == 1'b1, "R3 wr_ready back", 64'(wr_ready), 64'd1);

    // R4 / R5: single events, both groups, timestamps off for some
    pulse(0, 1); wait_cyc(5);
    pulse(3, 1); wait_cyc(5);
    ts_enable = 1'b0;
    pulse(4, 1); wait_cyc(5);
    pulse(31, 1); wait_cyc(5);
    ts_enable = 1'b1;
    drain();
    check(q.size() == 0, "R4 all event messages seen", 64'(q.size()), 64'd0);

    // R6 / R7: stalled output, mixed pending requests
    m_ready = 1'b0;
    sw_write(2'd2, 16'h0777, 8'h01, 32'h12345678, 1);
    wait_cyc(3);
    pulse(9, 0); wait_cyc(2);
    pulse(2, 0); wait_cyc(2);
    pulse(20, 0); wait_cyc(2);
    sw_write(2'd0, 16'h0099, 8'h00, 32'hcafef00d, 0);
    q.push_back('{1'b1, 1'b1, 2'd0, 16'd2, 32'd0});
    q.push_back('{1'b1, 1'b0, 2'd0, 16'd9, 32'd0});
    q.push_back('{1'b1, 1'b0, 2'd0, 16'd20, 32'd0});
    q.push_back('{1'b0, 1'b0, 2'd0, 16'h0099, 32'hcafef00d});
    wait_cyc(5);
    check(m_valid == 1'b1 && m_id == 16'h0777, "R11 stalled message held", 64'(m_id), 64'h777);
    drain();
    check(q.size() == 0, "R6 pulses not lost", 64'(q.size()), 64'd0);

    // R8: overflow counting and saturation
    m_ready = 1'b0;
    sw_write(2'd1, 16'h0005, 8'h00, 32'h0, 1);
    wait_cyc(3);
    pulse(5, 1); wait_cyc(3);
    check(ovf_count == 8'd0, "R8 first edge not overflow", 64'(ovf_count), 64'd0);
    pulse(5, 0); wait_cyc(3);
    check(ovf_count == 8'd1, "R8 second edge counted", 64'(ovf_count), 64'd1);
    pulse(5, 0); wait_cyc(3);
    check(ovf_count == 8'd2, "R8 third edge counted", 64'(ovf_count), 64'd2);
    for (int i = 0; i < 260; i++) pulse(5, 0);
    wait_cyc(4);
    check(ovf_count == 8'd255, "R8 saturation", 64'(ovf_count), 64'd255);
    drain();
    check(q.size() == 0 && ovf_count == 8'd255, "R8 single message for pending line", 64'(q.size()), 64'd0);

    finish_run();
  end
endmodule